// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block produces fetch addresses for a processor whose control transfers are delayed by one instruction and whose instructions are all 4 bytes long. It keeps two address registers. The first is the address of the instruction executing in the current cycle. The second is the address of the instruction that follows it. A taken transfer rewrites only the second register. As a result, the instruction right after a branch, call or jump, called the delay slot, always runs before control reaches the target.

Each cycle the decoder supplies the following for the instruction at `fetchPc`:
- the kind of control transfer (none, conditional branch, call, or jump-and-link);
- the evaluated branch condition;
- the annul bit;
- the target address;
- the destination register of a jump-and-link.

The sequencer uses these to advance its two registers. It can mark the delay slot as squashed, and it then ignores whatever that squashed slot decodes to. It also reports the link write for the register file and flags a transfer to a target that is not word aligned.

Top module: `fetch_seq_top`

## Requirements
- R1: While `rstN` is low at a rising clock edge, `fetchPc` becomes 0, `nextPc` becomes 4 and `annulNext` becomes 0.
- R2: When no transfer is redirected in a cycle, the next edge moves `nextPc` into `fetchPc` and sets `nextPc` to the old `nextPc` plus 4.
- R3: A taken transfer whose target has its low two bits zero moves `nextPc` into `fetchPc` and loads the target into `nextPc`, so the delay-slot instruction is fetched before the target.
- R4: A conditional branch (`xferKind` = 1) with `condTaken` low and `annulBit` low follows R2, and its delay slot is not squashed (`annulNext` stays 0).
- R5: A conditional branch with `annulBit` high and `condTaken` low sets `annulNext` to 1 for the next cycle. With `condTaken` high it leaves `annulNext` at 0. `annulBit` has no effect on a call (`xferKind` = 2) or a jump-and-link (`xferKind` = 3).
- R6: While `annulNext` is 1, the inputs of the current slot cause no redirect, no link write, no alignment error and no new squash. The squashed slot follows R2, and `annulNext` returns to 0 on the next edge.
- R7: A transfer that would be taken with a target whose low two bits are nonzero drives `alignErr` high in that cycle, does not redirect, and does not write a link. A not-taken branch to such a target raises no error.
- R8: A call is always taken regardless of `condTaken`. It drives `linkWe` high with `linkDest` = 15 and `linkValue` = the call's own `fetchPc`.
- R9: A jump-and-link is always taken. It drives `linkDest` = `jmplRd` and `linkValue` = its own `fetchPc`. `linkWe` is high only when `jmplRd` is nonzero, so a return that names register 0 discards the link.
- R10: `fetchPc` and `nextPc` always have their low two bits zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous active-low reset |
| xferKind | input | 2 | 0 none, 1 conditional branch, 2 call, 3 jump-and-link |
| condTaken | input | 1 | Evaluated branch condition |
| annulBit | input | 1 | Annul bit of a conditional branch |
| targetAddr | input | 32 | Transfer target address |
| jmplRd | input | 5 | Destination register of a jump-and-link |
| fetchPc | output | 32 | Address of the instruction executing this cycle |
| nextPc | output | 32 | Address of the following instruction |
| annulNext | output | 1 | The instruction at `fetchPc` is squashed |
| linkWe | output | 1 | Register-file write of the link value |
| linkDest | output | 5 | Destination register of the link write |
| linkValue | output | 32 | Link value (address of the transfer instruction) |
| alignErr | output | 1 | Misaligned transfer target |

## Verification
The bench first runs a sequence of straight-line code, then branches taken and not taken, each with and without the annul bit. Comparing the address stream across these cases separates a delay slot that is executed from one that is skipped, and a delayed redirect from an immediate one. Calls and jump-and-links are issued with the condition and annul inputs set against them, which shows that both are ignored for unconditional transfers. A return to register 0 shows that the link write is dropped. A transfer placed in a squashed slot, and misaligned targets on both taken and not-taken branches, separate the suppression paths from the normal ones. Back-to-back annulling branches check that a squashed slot cannot extend the squash.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

  typedef enum logic [1:0] {
    XFER_NONE = 2'd0,
    XFER_BR   = 2'd1,
    XFER_CALL = 2'd2,
    XFER_JMPL = 2'd3
  } xfer_kind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadTarget;   // redirect nextPc to the target
    logic keepLink;     // current pc is a link value being written
  } seq_strobe_t;

endpackage

// File: rtl/fetch_seq_ctrl.sv
module fetch_seq_ctrl
  import fetch_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int REG_IDX_W = 5,
  parameter int LINK_REG  = 15,
  parameter int INSTR_B   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           xferKind,
  input  logic                 condTaken,
  input  logic                 annulBit,
  input  logic [ADDR_W-1:0]    targetAddr,
  input  logic [REG_IDX_W-1:0] jmplRd,
  output seq_strobe_t          stb,
  output logic                 squashNow,
  output logic                 linkWe,
  output logic [REG_IDX_W-1:0] linkDest,
  output logic                 alignErr
);

  localparam int ALIGN_W = $clog2(INSTR_B);

  xfer_kind_e kind;
  logic squashQ;
  logic active, isBranch, isLink, wantRedirect, misaligned, setSquash;

  assign kind     = xfer_kind_e'(xferKind);
  assign active   = !squashQ;
  assign isBranch = (kind == XFER_BR);
  assign isLink   = (kind == XFER_CALL) || (kind == XFER_JMPL);

  generate
    if (ALIGN_W > 0) begin : g_align
      assign misaligned = |targetAddr[ALIGN_W-1:0];
    end else begin : g_noalign
      assign misaligned = 1'b0;
    end
  endgenerate

  always_comb begin
    wantRedirect   = active && (isLink || (isBranch && condTaken));
    alignErr       = wantRedirect && misaligned;
    stb.loadTarget = wantRedirect && !misaligned;
    stb.keepLink   = active && isLink && !misaligned;
    linkDest       = (kind == XFER_CALL) ? REG_IDX_W'(LINK_REG) : jmplRd;
    linkWe         = stb.keepLink && (linkDest != '0);
    setSquash      = active && isBranch && annulBit && !condTaken;
  end

  always_ff @(posedge clk) begin
    if (!rstN) squashQ <= 1'b0;
    else       squashQ <= setSquash;
  end

  assign squashNow = squashQ;

  // R6: a squashed slot issues nothing
  a_r6_squash_quiet: assert property (@(posedge clk) disable iff (!rstN)
    squashQ |-> (!stb.loadTarget && !linkWe && !alignErr));
  // R6: squash never extends past one slot
  a_r6_single_squash: assert property (@(posedge clk) disable iff (!rstN)
    squashQ |=> !squashQ);
  // R5: annulled not-taken branch squashes its slot
  a_r5_annul_sets: assert property (@(posedge clk) disable iff (!rstN)
    (!squashQ && xferKind == 2'd1 && annulBit && !condTaken) |=> squashQ);
  // R7: a faulting transfer neither redirects nor links
  a_r7_err_no_effect: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> (!stb.loadTarget && !linkWe));
  // R8: a call to an aligned target always redirects
  a_r8_call_taken: assert property (@(posedge clk) disable iff (!rstN)
    (!squashQ && xferKind == 2'd2 && targetAddr[1:0] == 2'b00) |-> (stb.loadTarget && linkWe));

endmodule

// File: rtl/fetch_seq_dp.sv
module fetch_seq_dp
  import fetch_seq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int INSTR_B  = 4,
  parameter int RESET_PC = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       stb,
  input  logic [ADDR_W-1:0] targetAddr,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] npcOut,
  output logic [ADDR_W-1:0] linkValue
);

  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(INSTR_B);
  localparam logic [ADDR_W-1:0] PC_INIT = ADDR_W'(RESET_PC);

  logic [ADDR_W-1:0] pcQ, npcQ, npcNext;

  assign npcNext = stb.loadTarget ? targetAddr : (npcQ + STEP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ  <= PC_INIT;
      npcQ <= PC_INIT + STEP;
    end else begin
      pcQ  <= npcQ;
      npcQ <= npcNext;
    end
  end

  assign pcOut     = pcQ;
  assign npcOut    = npcQ;
  assign linkValue = stb.keepLink ? pcQ : '0;

  // R2: sequential step when no redirect
  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadTarget |=> (pcQ == $past(npcQ) && npcQ == $past(npcQ) + STEP));
  // R3: redirect lands in nextPc only
  a_r3_delayed_redirect: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadTarget |=> (pcQ == $past(npcQ) && npcQ == $past(targetAddr)));
  // R10: addresses stay word aligned
  a_r10_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (pcQ[1:0] == 2'b00 && npcQ[1:0] == 2'b00));

endmodule

// File: rtl/fetch_seq_top.sv
module fetch_seq_top
  import fetch_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int REG_IDX_W = 5,
  parameter int LINK_REG  = 15,
  parameter int INSTR_B   = 4,
  parameter int RESET_PC  = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           xferKind,
  input  logic                 condTaken,
  input  logic                 annulBit,
  input  logic [ADDR_W-1:0]    targetAddr,
  input  logic [REG_IDX_W-1:0] jmplRd,
  output logic [ADDR_W-1:0]    fetchPc,
  output logic [ADDR_W-1:0]    nextPc,
  output logic                 annulNext,
  output logic                 linkWe,
  output logic [REG_IDX_W-1:0] linkDest,
  output logic [ADDR_W-1:0]    linkValue,
  output logic                 alignErr
);

  seq_strobe_t stb;

  fetch_seq_ctrl #(
    .ADDR_W(ADDR_W), .REG_IDX_W(REG_IDX_W), .LINK_REG(LINK_REG), .INSTR_B(INSTR_B)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .xferKind(xferKind), .condTaken(condTaken),
    .annulBit(annulBit), .targetAddr(targetAddr), .jmplRd(jmplRd),
    .stb(stb), .squashNow(annulNext), .linkWe(linkWe), .linkDest(linkDest),
    .alignErr(alignErr)
  );

  fetch_seq_dp #(
    .ADDR_W(ADDR_W), .INSTR_B(INSTR_B), .RESET_PC(RESET_PC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .targetAddr(targetAddr),
    .pcOut(fetchPc), .npcOut(nextPc), .linkValue(linkValue)
  );

endmodule

// File: tb/tb_fetch_seq_top.sv
module tb_fetch_seq_top;

  typedef struct packed {
    logic [1:0]  kind;
    logic        tk;
    logic        an;
    logic [31:0] tgt;
    logic [4:0]  rd;
    logic [31:0] expPc;
    logic [31:0] expNpc;
    logic        expAn;
    logic        expWe;
    logic        expErr;
  } vec_t;

  localparam int NV = 16;
  // kind tk an tgt rd | pc npc annul we err  (values seen before the edge)
  localparam vec_t VECS [NV] = '{
    '{2'd0,1'b0,1'b0,32'h000,5'd0, 32'h000,32'h004,1'b0,1'b0,1'b0}, // R2 straight line
    '{2'd1,1'b1,1'b0,32'h100,5'd0, 32'h004,32'h008,1'b0,1'b0,1'b0}, // R3 taken branch
    '{2'd0,1'b0,1'b0,32'h000,5'd0, 32'h008,32'h100,1'b0,1'b0,1'b0}, // R3 delay slot runs
    '{2'd1,1'b0,1'b0,32'h200,5'd0, 32'h100,32'h104,1'b0,1'b0,1'b0}, // R4 not taken
    '{2'd1,1'b0,1'b1,32'h200,5'd0, 32'h104,32'h108,1'b0,1'b0,1'b0}, // R5 annul not taken
    '{2'd2,1'b1,1'b0,32'h300,5'd0, 32'h108,32'h10C,1'b1,1'b0,1'b0}, // R6 squashed call
    '{2'd1,1'b1,1'b1,32'h400,5'd0, 32'h10C,32'h110,1'b0,1'b0,1'b0}, // R5 annul taken
    '{2'd0,1'b0,1'b0,32'h000,5'd0, 32'h110,32'h400,1'b0,1'b0,1'b0}, // R5 slot executes
    '{2'd2,1'b0,1'b1,32'h500,5'd0, 32'h400,32'h404,1'b0,1'b1,1'b0}, // R8 call, cond/annul off
    '{2'd3,1'b0,1'b0,32'h508,5'd0, 32'h404,32'h500,1'b0,1'b0,1'b0}, // R9 return to r0
    '{2'd3,1'b1,1'b0,32'h602,5'd7, 32'h500,32'h508,1'b0,1'b0,1'b1}, // R7 misaligned jump
    '{2'd1,1'b0,1'b0,32'h701,5'd0, 32'h508,32'h50C,1'b0,1'b0,1'b0}, // R7 not taken, no err
    '{2'd1,1'b1,1'b0,32'h703,5'd0, 32'h50C,32'h510,1'b0,1'b0,1'b1}, // R7 taken misaligned
    '{2'd3,1'b0,1'b1,32'h800,5'd9, 32'h510,32'h514,1'b0,1'b1,1'b0}, // R9 link to r9
    '{2'd1,1'b1,1'b1,32'h900,5'd0, 32'h514,32'h800,1'b0,1'b0,1'b0}, // R3 branch in slot
    '{2'd0,1'b0,1'b0,32'h000,5'd0, 32'h800,32'h900,1'b0,1'b0,1'b0}  // R10 aligned flow
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  xferKind = 2'd0;
  logic        condTaken = 1'b0;
  logic        annulBit = 1'b0;
  logic [31:0] targetAddr = '0;
  logic [4:0]  jmplRd = '0;
  logic [31:0] fetchPc, nextPc, linkValue;
  logic        annulNext, linkWe, alignErr;
  logic [4:0]  linkDest;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  fetch_seq_top dut (
    .clk(clk), .rstN(rstN), .xferKind(xferKind), .condTaken(condTaken),
    .annulBit(annulBit), .targetAddr(targetAddr), .jmplRd(jmplRd),
    .fetchPc(fetchPc), .nextPc(nextPc), .annulNext(annulNext),
    .linkWe(linkWe), .linkDest(linkDest), .linkValue(linkValue),
    .alignErr(alignErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] k, input logic t, input logic a,
                       input logic [31:0] g, input logic [4:0] r);
    xferKind = k; condTaken = t; annulBit = a; targetAddr = g; jmplRd = r;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 fetchPc", fetchPc, 32'h0);
    chk("R1 nextPc", nextPc, 32'h4);
    chk("R1 annulNext", {31'b0, annulNext}, 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].kind, VECS[i].tk, VECS[i].an, VECS[i].tgt, VECS[i].rd);
      #1;
      chk("R2/R3 fetchPc", fetchPc, VECS[i].expPc);
      chk("R2/R3 nextPc", nextPc, VECS[i].expNpc);
      chk("R5/R6 annulNext", {31'b0, annulNext}, {31'b0, VECS[i].expAn});
      chk("R8/R9 linkWe", {31'b0, linkWe}, {31'b0, VECS[i].expWe});
      chk("R7 alignErr", {31'b0, alignErr}, {31'b0, VECS[i].expErr});
      if (VECS[i].expWe) begin
        chk("R8/R9 linkDest", {27'b0, linkDest}, (VECS[i].kind == 2'd2) ? 32'd15 : {27'b0, VECS[i].rd});
        chk("R8/R9 linkValue", linkValue, VECS[i].expPc);
      end
      @(negedge clk);
    end

    // R4/R10: flow after the table continues sequentially from 0x900
    drive(2'd1, 1'b0, 1'b1, 32'hA00, 5'd0); // R5 annul, not taken
    #1;
    chk("R2 fetchPc after table", fetchPc, 32'h900);
    @(negedge clk);
    // R6: squashed slot holding another annulling not-taken branch
    drive(2'd1, 1'b0, 1'b1, 32'hB00, 5'd0);
    #1;
    chk("R6 squash active", {31'b0, annulNext}, 32'h1);
    chk("R6 no error in squashed slot", {31'b0, alignErr}, 32'h0);
    @(negedge clk);
    drive(2'd0, 1'b0, 1'b0, 32'h0, 5'd0);
    #1;
    chk("R6 squash does not extend", {31'b0, annulNext}, 32'h0);
    chk("R6 squashed slot sequential", fetchPc, 32'h908);
    chk("R6 nextPc", nextPc, 32'h90C);
    @(negedge clk);

    // R1: reset in mid-run after a pending squash
    drive(2'd1, 1'b0, 1'b1, 32'hC00, 5'd0);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 mid-run fetchPc", fetchPc, 32'h0);
    chk("R1 mid-run nextPc", nextPc, 32'h4);
    chk("R1 mid-run annulNext", {31'b0, annulNext}, 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule